// File: doc/BRIEF.md
# CPU Interrupt and Bus-Request Arbiter

This block sits next to a small 8-bit CPU sequencer. At each cycle boundary it decides whether the processor keeps executing, gives the system bus to an external master, or starts an interrupt acknowledge cycle. It watches an active-low bus request, an active-low non-maskable interrupt line and a parameterised set of active-low maskable interrupt lines. The sequencer tells it where the boundaries fall through two pulse inputs: end of machine cycle and end of instruction. It also receives the current interrupt-enable state as a plain input.

A bus request is taken at any machine-cycle boundary and outranks everything else. While the bus is granted, the block drives its acknowledge low and raises a tri-state enable that floats the address bus, the data bus and the control strobes. Interrupts are taken only at instruction boundaries, in this order: the latched non-maskable edge first, then the maskable lines by index. Only maskable line 0 gets an acknowledge cycle with the opcode-fetch and I/O-request strobes, which ask the device to place a vector on the data bus. Every acknowledge cycle reports which source is being served.

Top module: `irq_bus_arbiter`

## Requirements
- R1: After a synchronous reset, busack_n, ack_m1_n and ack_iorq_n are 1, and bus_hiz, ack_active and ack_src are 0.
- R2: From the run state, busreq_n low at a boundary (mcycle_end or instr_end high) gives busack_n=0 and bus_hiz=1 from the next clock edge. This holds even when a non-maskable or maskable request is present at the same boundary.
- R3: From the run state, in a cycle where neither mcycle_end nor instr_end is high, no request of any kind changes the outputs.
- R4: The grant holds while busreq_n stays low, and boundaries during the grant start nothing. On the first clock edge that samples busreq_n high, busack_n returns to 1, bus_hiz returns to 0 and arbitration resumes.
- R5: A falling edge on nmi_n sets a pending flag that survives the line returning high and survives a bus grant. The flag clears only when its acknowledge begins. A line held low produces one acknowledge only.
- R6: At instr_end with no bus request and the non-maskable flag pending, an acknowledge with ack_src=1 starts. This does not depend on int_enable or on the maskable lines.
- R7: Maskable lines are level sensitive. They count only at instr_end and only while int_enable is 1. At an mcycle_end alone, or while int_enable is 0, they are ignored.
- R8: Among the maskable lines the lowest index wins. Line k is reported as ack_src=2+k, which is 2, 3 or 4 for three lines.
- R9: During an acknowledge of maskable line 0, ack_m1_n and ack_iorq_n are both 0 for the whole cycle. For every other source both stay 1.
- R10: An acknowledge keeps ack_active=1 and ack_src steady for ACK_CYCLES clock cycles and then returns to run with ack_src=0. Requests seen during it have no effect until the next boundary in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busreq_n | input | 1 | External bus request, active low |
| nmi_n | input | 1 | Non-maskable interrupt, falling-edge triggered |
| int_n | input | NUM_MASK | Maskable interrupt requests, active low, index 0 highest |
| mcycle_end | input | 1 | Pulse marking the last cycle of a machine cycle |
| instr_end | input | 1 | Pulse marking the last cycle of an instruction |
| int_enable | input | 1 | Maskable interrupts currently enabled |
| busack_n | output | 1 | Bus acknowledge, active low |
| bus_hiz | output | 1 | Float address bus, data bus and strobes |
| ack_m1_n | output | 1 | Opcode-fetch strobe of the acknowledge cycle, active low |
| ack_iorq_n | output | 1 | I/O-request strobe of the acknowledge cycle, active low |
| ack_active | output | 1 | Interrupt acknowledge cycle in progress |
| ack_src | output | $clog2(NUM_MASK+2) | Source served: 0 none, 1 non-maskable, 2+k maskable line k |

## Verification
The bench builds the block with three maskable lines, which covers both priority steps among them. It sets ACK_CYCLES to 3 instead of the default 2, so the acknowledge cycle has a middle cycle. Requests are asserted during that cycle to show they are ignored and that ack_src holds steady. With these settings the bench can also run a short non-maskable pulse through a bus grant and still see its deferred acknowledge afterwards.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_GRANT = 2'd1,
        ST_ACK   = 2'd2
    } arb_state_e;

    localparam int SRC_NONE      = 0;
    localparam int SRC_NMI       = 1;
    localparam int SRC_MASK_BASE = 2;

    typedef struct packed {
        logic busack_n;
        logic bus_hiz;
        logic m1_n;
        logic iorq_n;
        logic active;
    } arb_out_t;

    function automatic arb_out_t idle_out();
        arb_out_t o;
        o.busack_n = 1'b1;
        o.bus_hiz  = 1'b0;
        o.m1_n     = 1'b1;
        o.iorq_n   = 1'b1;
        o.active   = 1'b0;
        return o;
    endfunction

    function automatic arb_out_t grant_out();
        arb_out_t o;
        o          = idle_out();
        o.busack_n = 1'b0;
        o.bus_hiz  = 1'b1;
        return o;
    endfunction

    function automatic arb_out_t ack_out(input logic with_strobes);
        arb_out_t o;
        o        = idle_out();
        o.active = 1'b1;
        o.m1_n   = ~with_strobes;
        o.iorq_n = ~with_strobes;
        return o;
    endfunction

endpackage

// File: rtl/irqarb_nmi_latch.sv
module irqarb_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_n,
    input  logic take,
    output logic pending
);
    logic prev_q;
    logic pend_q;
    logic fall;

    assign fall    = prev_q & ~nmi_n;
    assign pending = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            prev_q <= nmi_n;
            if (fall)
                pend_q <= 1'b1;
            else if (take)
                pend_q <= 1'b0;
        end
    end

    // R5: a detected falling edge always leaves the flag set
    assert_edge_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (prev_q && !nmi_n) |=> pend_q);

    // R5: the flag is only dropped by the start of its acknowledge
    assert_pending_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !take) |=> pend_q);

endmodule

// File: rtl/irqarb_prio.sv
module irqarb_prio #(
    parameter int NUM_MASK = 3,
    parameter int SRC_W    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                nmi_pending,
    input  logic [NUM_MASK-1:0] int_n,
    input  logic                int_enable,
    output logic                any_req,
    output logic [SRC_W-1:0]    pick_src
);
    import irqarb_pkg::*;

    logic [NUM_MASK-1:0] req;
    logic [NUM_MASK-1:0] sel;
    logic [NUM_MASK:0]   blocked;

    assign blocked[0] = nmi_pending;

    for (genvar g = 0; g < NUM_MASK; g++) begin : g_chain
        assign req[g]       = int_enable & ~int_n[g];
        assign sel[g]       = req[g] & ~blocked[g];
        assign blocked[g+1] = blocked[g] | req[g];
    end

    assign any_req = blocked[NUM_MASK];

    always_comb begin
        pick_src = nmi_pending ? SRC_W'(SRC_NMI) : SRC_W'(SRC_NONE);
        for (int i = 0; i < NUM_MASK; i++) begin
            if (sel[i])
                pick_src = SRC_W'(SRC_MASK_BASE + i);
        end
    end

    // R8: at most one source wins the chain
    assert_single_winner_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({nmi_pending, sel}));

endmodule

// File: rtl/irqarb_ctrl.sv
module irqarb_ctrl #(
    parameter int ACK_CYCLES = 2,
    parameter int SRC_W      = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busreq_n,
    input  logic             mcycle_end,
    input  logic             instr_end,
    input  logic             any_req,
    input  logic [SRC_W-1:0] pick_src,
    output logic             nmi_take,
    output logic             busack_n,
    output logic             bus_hiz,
    output logic             ack_m1_n,
    output logic             ack_iorq_n,
    output logic             ack_active,
    output logic [SRC_W-1:0] ack_src
);
    import irqarb_pkg::*;

    localparam int CNT_W = (ACK_CYCLES > 1) ? $clog2(ACK_CYCLES) : 1;

    arb_state_e       state_q;
    arb_out_t         out_q;
    logic [SRC_W-1:0] src_q;
    logic [CNT_W-1:0] cnt_q;
    logic             boundary;
    logic             go_grant;
    logic             go_ack;

    assign boundary = mcycle_end | instr_end;
    assign go_grant = (state_q == ST_RUN) && boundary && !busreq_n;
    assign go_ack   = (state_q == ST_RUN) && instr_end && busreq_n && any_req;
    assign nmi_take = go_ack && (pick_src == SRC_W'(SRC_NMI));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            out_q   <= idle_out();
            src_q   <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (go_grant) begin
                        state_q <= ST_GRANT;
                        out_q   <= grant_out();
                    end else if (go_ack) begin
                        state_q <= ST_ACK;
                        out_q   <= ack_out(pick_src == SRC_W'(SRC_MASK_BASE));
                        src_q   <= pick_src;
                        cnt_q   <= CNT_W'(ACK_CYCLES - 1);
                    end
                end
                ST_GRANT: begin
                    if (busreq_n) begin
                        state_q <= ST_RUN;
                        out_q   <= idle_out();
                    end
                end
                ST_ACK: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_RUN;
                        out_q   <= idle_out();
                        src_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_RUN;
                    out_q   <= idle_out();
                    src_q   <= '0;
                end
            endcase
        end
    end

    assign busack_n   = out_q.busack_n;
    assign bus_hiz    = out_q.bus_hiz;
    assign ack_m1_n   = out_q.m1_n;
    assign ack_iorq_n = out_q.iorq_n;
    assign ack_active = out_q.active;
    assign ack_src    = src_q;

    // R2: a bus request at any boundary in run is granted on the next edge
    assert_grant_on_boundary_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && (mcycle_end || instr_end) && !busreq_n)
        |=> (!busack_n && bus_hiz));

    // R3: without a boundary nothing starts
    assert_idle_without_boundary_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !mcycle_end && !instr_end)
        |=> (busack_n && !ack_active));

    // R4: released on the edge that sees the request withdrawn
    assert_release_R4: assert property (@(posedge clk) disable iff (rst)
        (!busack_n && busreq_n) |=> (busack_n && !bus_hiz));

    // R9: strobes only ever accompany an acknowledge of maskable line 0
    assert_strobes_line0_R9: assert property (@(posedge clk) disable iff (rst)
        (!ack_m1_n || !ack_iorq_n) |-> (ack_active && ack_src == SRC_W'(SRC_MASK_BASE)));

    // R10: the acknowledge is not cut short and its source stays put
    assert_ack_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (ack_active && cnt_q != '0) |=> (ack_active && $stable(ack_src)));

endmodule

// File: rtl/irq_bus_arbiter.sv
module irq_bus_arbiter #(
    parameter int NUM_MASK   = 3,
    parameter int ACK_CYCLES = 2,
    localparam int SRC_W     = $clog2(NUM_MASK + 2)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                busreq_n,
    input  logic                nmi_n,
    input  logic [NUM_MASK-1:0] int_n,
    input  logic                mcycle_end,
    input  logic                instr_end,
    input  logic                int_enable,
    output logic                busack_n,
    output logic                bus_hiz,
    output logic                ack_m1_n,
    output logic                ack_iorq_n,
    output logic                ack_active,
    output logic [SRC_W-1:0]    ack_src
);
    logic             nmi_pending;
    logic             nmi_take;
    logic             any_req;
    logic [SRC_W-1:0] pick_src;

    irqarb_nmi_latch u_nmi (
        .clk     (clk),
        .rst     (rst),
        .nmi_n   (nmi_n),
        .take    (nmi_take),
        .pending (nmi_pending)
    );

    irqarb_prio #(
        .NUM_MASK (NUM_MASK),
        .SRC_W    (SRC_W)
    ) u_prio (
        .clk         (clk),
        .rst         (rst),
        .nmi_pending (nmi_pending),
        .int_n       (int_n),
        .int_enable  (int_enable),
        .any_req     (any_req),
        .pick_src    (pick_src)
    );

    irqarb_ctrl #(
        .ACK_CYCLES (ACK_CYCLES),
        .SRC_W      (SRC_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .busreq_n   (busreq_n),
        .mcycle_end (mcycle_end),
        .instr_end  (instr_end),
        .any_req    (any_req),
        .pick_src   (pick_src),
        .nmi_take   (nmi_take),
        .busack_n   (busack_n),
        .bus_hiz    (bus_hiz),
        .ack_m1_n   (ack_m1_n),
        .ack_iorq_n (ack_iorq_n),
        .ack_active (ack_active),
        .ack_src    (ack_src)
    );

endmodule

// File: tb/irq_bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_bus_arbiter_tb_top;

    localparam int NUM_MASK   = 3;
    localparam int ACK_CYCLES = 3;
    localparam int SRC_W      = $clog2(NUM_MASK + 2);
    localparam int K_IDLE  = 0;
    localparam int K_GRANT = 1;
    localparam int K_ACK   = 2;

    typedef struct {
        string            tag;
        logic             busack_n;
        logic             bus_hiz;
        logic             m1_n;
        logic             iorq_n;
        logic             active;
        logic [SRC_W-1:0] src;
    } exp_t;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                busreq_n = 1'b1;
    logic                nmi_n = 1'b1;
    logic [NUM_MASK-1:0] int_n = '1;
    logic                mcycle_end = 1'b0;
    logic                instr_end = 1'b0;
    logic                int_enable = 1'b0;
    logic                busack_n, bus_hiz, ack_m1_n, ack_iorq_n, ack_active;
    logic [SRC_W-1:0]    ack_src;

    int   tests = 0;
    int   fails = 0;
    bit   done  = 0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    irq_bus_arbiter #(.NUM_MASK(NUM_MASK), .ACK_CYCLES(ACK_CYCLES)) dut_i (
        .clk(clk), .rst(rst), .busreq_n(busreq_n), .nmi_n(nmi_n), .int_n(int_n),
        .mcycle_end(mcycle_end), .instr_end(instr_end), .int_enable(int_enable),
        .busack_n(busack_n), .bus_hiz(bus_hiz), .ack_m1_n(ack_m1_n),
        .ack_iorq_n(ack_iorq_n), .ack_active(ack_active), .ack_src(ack_src)
    );

    // driver: set inputs for one cycle and queue what must appear after the edge
    task automatic cyc(input string tag, input logic b, input logic nmi,
                       input logic [NUM_MASK-1:0] ints, input logic me,
                       input logic ie, input logic en, input int kind,
                       input int src);
        exp_t e;
        @(negedge clk);
        busreq_n   = b;
        nmi_n      = nmi;
        int_n      = ints;
        mcycle_end = me;
        instr_end  = ie;
        int_enable = en;
        e.tag      = tag;
        e.busack_n = (kind != K_GRANT);
        e.bus_hiz  = (kind == K_GRANT);
        e.active   = (kind == K_ACK);
        e.src      = (kind == K_ACK) ? SRC_W'(src) : '0;
        e.m1_n     = !((kind == K_ACK) && src == 2);
        e.iorq_n   = e.m1_n;
        exp_q.push_back(e);
    endtask

    // monitor: compare just after each edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                tests++;
                if (busack_n !== e.busack_n || bus_hiz !== e.bus_hiz ||
                    ack_m1_n !== e.m1_n || ack_iorq_n !== e.iorq_n ||
                    ack_active !== e.active || ack_src !== e.src) begin
                    fails++;
                    $display("FAIL %s: got busack_n=%b hiz=%b m1_n=%b iorq_n=%b act=%b src=%0d exp %b %b %b %b %b %0d",
                             e.tag, busack_n, bus_hiz, ack_m1_n, ack_iorq_n, ack_active, ack_src,
                             e.busack_n, e.bus_hiz, e.m1_n, e.iorq_n, e.active, e.src);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        cyc("R1", 1, 1, 3'b111, 0, 0, 0, K_IDLE, 0);
        cyc("R1", 1, 1, 3'b111, 0, 0, 0, K_IDLE, 0);
        @(posedge clk);
        #1 rst = 1'b0;

        // R7 maskable ignored at machine-cycle end alone and while disabled
        cyc("R7", 1, 1, 3'b110, 1, 0, 1, K_IDLE, 0);
        cyc("R7", 1, 1, 3'b110, 0, 1, 0, K_IDLE, 0);
        // R3 no boundary: nothing starts
        cyc("R3", 1, 1, 3'b000, 0, 0, 1, K_IDLE, 0);

        // R9 line 0 acknowledge with strobes; R10 requests during it ignored
        cyc("R9", 1, 1, 3'b110, 0, 1, 1, K_ACK, 2);
        cyc("R10", 1, 1, 3'b001, 0, 1, 1, K_ACK, 2);
        cyc("R10", 1, 1, 3'b111, 0, 0, 0, K_ACK, 2);
        cyc("R10", 1, 1, 3'b111, 0, 0, 0, K_IDLE, 0);

        // R8 line 1 beats line 2, no strobes
        cyc("R8", 1, 1, 3'b001, 0, 1, 1, K_ACK, 3);
        cyc("R8", 1, 1, 3'b111, 0, 0, 0, K_ACK, 3);
        cyc("R8", 1, 1, 3'b111, 0, 0, 0, K_ACK, 3);
        cyc("R8", 1, 1, 3'b111, 0, 0, 0, K_IDLE, 0);
        // R8 line 2 alone
        cyc("R8", 1, 1, 3'b011, 0, 1, 1, K_ACK, 4);
        cyc("R8", 1, 1, 3'b111, 0, 0, 0, K_ACK, 4);
        cyc("R8", 1, 1, 3'b111, 0, 0, 0, K_ACK, 4);
        cyc("R8", 1, 1, 3'b111, 0, 0, 0, K_IDLE, 0);
        // R8 line 0 beats lines 1 and 2
        cyc("R8", 1, 1, 3'b000, 0, 1, 1, K_ACK, 2);
        cyc("R8", 1, 1, 3'b111, 0, 0, 0, K_ACK, 2);
        cyc("R8", 1, 1, 3'b111, 0, 0, 0, K_ACK, 2);
        cyc("R8", 1, 1, 3'b111, 0, 0, 0, K_IDLE, 0);

        // R5 short non-maskable pulse kept until an instruction end
        cyc("R5", 1, 0, 3'b111, 0, 0, 0, K_IDLE, 0);
        cyc("R5", 1, 1, 3'b111, 0, 0, 0, K_IDLE, 0);
        cyc("R5", 1, 1, 3'b111, 1, 0, 0, K_IDLE, 0);
        // R6 beats line 0 and ignores int_enable
        cyc("R6", 1, 1, 3'b110, 0, 1, 0, K_ACK, 1);
        cyc("R6", 1, 1, 3'b111, 0, 0, 0, K_ACK, 1);
        cyc("R6", 1, 1, 3'b111, 0, 0, 0, K_ACK, 1);
        cyc("R6", 1, 1, 3'b111, 0, 0, 0, K_IDLE, 0);
        // R5 flag cleared by its acknowledge
        cyc("R5", 1, 1, 3'b111, 0, 1, 0, K_IDLE, 0);
        // R5 line held low gives a single acknowledge
        cyc("R5", 1, 0, 3'b111, 0, 0, 0, K_IDLE, 0);
        cyc("R5", 1, 0, 3'b111, 0, 1, 0, K_ACK, 1);
        cyc("R5", 1, 0, 3'b111, 0, 0, 0, K_ACK, 1);
        cyc("R5", 1, 0, 3'b111, 0, 0, 0, K_ACK, 1);
        cyc("R5", 1, 0, 3'b111, 0, 0, 0, K_IDLE, 0);
        cyc("R5", 1, 0, 3'b111, 0, 1, 0, K_IDLE, 0);
        cyc("R5", 1, 1, 3'b111, 0, 0, 0, K_IDLE, 0);

        // R3 bus request without a boundary; R2 granted at machine-cycle end
        cyc("R3", 0, 1, 3'b111, 0, 0, 0, K_IDLE, 0);
        cyc("R2", 0, 1, 3'b111, 1, 0, 0, K_GRANT, 0);
        // R4 boundaries during grant start nothing; release on the next edge
        cyc("R4", 0, 1, 3'b110, 0, 1, 1, K_GRANT, 0);
        cyc("R4", 1, 1, 3'b111, 0, 0, 0, K_IDLE, 0);

        // R2 bus request outranks pending non-maskable and line 0
        cyc("R5", 1, 0, 3'b111, 0, 0, 0, K_IDLE, 0);
        cyc("R2", 0, 1, 3'b110, 0, 1, 1, K_GRANT, 0);
        cyc("R4", 0, 1, 3'b111, 0, 0, 0, K_GRANT, 0);
        cyc("R4", 1, 1, 3'b111, 0, 0, 0, K_IDLE, 0);
        // R5 flag survived the grant
        cyc("R5", 1, 1, 3'b111, 0, 1, 1, K_ACK, 1);
        cyc("R10", 1, 1, 3'b111, 0, 0, 0, K_ACK, 1);
        cyc("R10", 1, 1, 3'b111, 0, 0, 0, K_ACK, 1);
        cyc("R10", 1, 1, 3'b111, 0, 0, 0, K_IDLE, 0);

        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule